// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs the digital side of a 10-bit successive-approximation converter. After a start request it steps through a fixed number of conversion periods. It presents a trial code to an external DAC, reads a one-bit comparator decision in each period, and builds the answer one bit at a time from the top bit down. When the last bit is resolved it stores the answer in a result register, drops its busy indication and sets a completion flag. That flag, combined with an enable, drives an interrupt request.

The period length comes from one of two sources. One is the system clock divided by a power of two, with six divisors chosen by a 3-bit select field. The other is a strobe from a separate slow RC oscillator, already synchronised to the block clock. While the core sleeps, the divided system clock is treated as stopped and a conversion that uses it freezes. A conversion timed by the RC strobe keeps running, and its interrupt can wake the core.

Top module: `sar_conv_ctrl`

## Requirements
- R1: The select field maps to system-clock divisors as follows: 000 gives 2, 100 gives 4, 001 gives 8, 101 gives 16, 010 gives 32 and 110 gives 64. A conversion keeps `busy` high for exactly 11 × divisor clock cycles.
- R2: A select value whose two low bits are 11 (011 or 111) times each period by `rc_tick`. The conversion ends on the 11th `rc_tick` strobe seen after the start is accepted.
- R3: In the cycle after the start is accepted, `dac_code` shows 10'h200. The first period makes no decision. Each of the next ten periods decides one bit, from bit 9 down to bit 0. A bit is kept when `cmp_in` is 1 at the end of its period, and the next lower bit is then set as the new trial.
- R4: `result` changes only in the cycle in which a conversion completes. It then holds the final code, which is the largest code not above the modelled input.
- R5: A `start_wr` pulse while idle sets `busy` at the next edge. `busy` clears at the same edge that loads `result` and sets `done_flag`.
- R6: A `start_wr` pulse while `busy` is high is ignored. The running conversion keeps its timing and its result.
- R7: `clk_sel` is captured when a start is accepted. A change to `clk_sel` during a conversion does not alter the length of that conversion.
- R8: `done_flag` is set by every completion, whatever the value of `irq_en`. It stays set until `flag_clr` is pulsed. If completion and `flag_clr` fall in the same cycle, the flag ends up set.
- R9: `irq` is high exactly when `done_flag` and `irq_en` are both high. This also holds while `core_sleep` is high.
- R10: While `core_sleep` is high, a conversion on a divided system clock makes no progress, and each sleeping cycle adds one cycle to its length. A conversion timed by the RC strobe keeps advancing.
- R11: After reset, `busy`, `done_flag`, `irq`, `result` and `dac_code` are all 0.
- R12: `dac_code` is 0 whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_sleep | input | 1 | High while the core sleeps; the divided system clock counts as stopped |
| rc_tick | input | 1 | One-cycle strobe from the synchronised RC oscillator |
| clk_sel | input | 3 | Conversion clock select |
| start_wr | input | 1 | Pulse to begin a conversion |
| flag_clr | input | 1 | Pulse to clear the completion flag |
| irq_en | input | 1 | Interrupt enable |
| cmp_in | input | 1 | Comparator decision: input at or above `dac_code` |
| busy | output | 1 | Conversion in progress |
| dac_code | output | 10 | Trial code for the DAC |
| result | output | 10 | Last completed conversion result |
| done_flag | output | 1 | Sticky completion flag |
| irq | output | 1 | Interrupt and wake request |

## Verification
Two events can land on the same edge: hardware completion setting `done_flag`, and a software clear. The bench waits for a divide-by-2 conversion to reach its final period and pulses `flag_clr` in the exact cycle of the completion edge. The flag must read 1 afterwards, both in a directed check and in the cycle-by-cycle model. A second overlap comes from a `start_wr` pulse and a `clk_sel` change issued in the middle of a run, together with sleep windows that cut into a divided-clock conversion. For these, the measured busy length and the result must match the unperturbed figures.

// File: rtl/sar_conv_pkg.sv
// Package: shared constants and helpers for the SAR conversion sequencer.
// Assumes the select encoding where bits [1:0] == 2'b11 mean the RC source.
package sar_conv_pkg;

    localparam int SEL_W   = 3;
    localparam int EXP_W   = 3;
    localparam int MAX_EXP = 6;

    typedef enum logic { CONV_IDLE = 1'b0, CONV_RUN = 1'b1 } conv_state_e;

    // Log2 of the system-clock divisor for a select value.
    function automatic logic [EXP_W-1:0] sel_to_exp(input logic [SEL_W-1:0] s);
        return {s[1:0], 1'b0} + {2'b00, s[2]} + 3'd1;
    endfunction

    // True when the select value picks the RC strobe.
    function automatic logic sel_is_rc(input logic [SEL_W-1:0] s);
        return s[1] & s[0];
    endfunction

endpackage

// File: rtl/sar_tick_gen.sv
// Module: produces one-cycle period-end ticks for a running conversion.
// Assumes sel_cap is stable while run is high; restart resets the divider.
module sar_tick_gen
    import sar_conv_pkg::*;
#(
    parameter int CNT_W = MAX_EXP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel_cap,
    input  logic             core_sleep,
    input  logic             rc_tick,
    output logic             tick
);

    logic             use_rc;
    logic [EXP_W-1:0] div_exp;
    logic [CNT_W-1:0] lim;
    logic [CNT_W-1:0] cnt;
    logic             sys_adv;
    logic             sys_wrap;

    // Decode the captured select into the source and the terminal count.
    always_comb begin
        use_rc  = sel_is_rc(sel_cap);
        div_exp = sel_to_exp(sel_cap);
        lim     = ~({CNT_W{1'b1}} << div_exp);
    end

    // Divided system clock advances only while awake and running.
    always_comb begin
        sys_adv  = run && !use_rc && !core_sleep;
        sys_wrap = sys_adv && (cnt == lim);
    end

    // Divider counter for the system-clock periods.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt <= '0;
        end else if (sys_adv) begin
            cnt <= sys_wrap ? '0 : cnt + 1'b1;
        end
    end

    // Select the period-end event from the active source.
    always_comb begin
        if (!run)        tick = 1'b0;
        else if (use_rc) tick = rc_tick;
        else             tick = sys_wrap;
    end

endmodule

// File: rtl/sar_seq.sv
// Module: start acceptance, busy state and period counting.
// Assumes one tick per period; the last period's tick ends the conversion.
module sar_seq
    import sar_conv_pkg::*;
#(
    parameter int PERIODS = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_wr,
    input  logic [SEL_W-1:0] clk_sel,
    input  logic             tick,
    output logic             busy,
    output logic             start_acc,
    output logic             decide,
    output logic             done,
    output logic [SEL_W-1:0] sel_cap
);

    localparam int PER_W = $clog2(PERIODS);
    localparam logic [PER_W-1:0] LAST = PER_W'(PERIODS - 1);

    conv_state_e      state;
    logic [PER_W-1:0] per;

    // Decode the events of this cycle from state, request and tick.
    always_comb begin
        busy      = (state == CONV_RUN);
        start_acc = !busy && start_wr;
        decide    = busy && tick && (per != '0);
        done      = busy && tick && (per == LAST);
    end

    // State and period counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CONV_IDLE;
            per   <= '0;
        end else if (start_acc) begin
            state <= CONV_RUN;
            per   <= '0;
        end else if (done) begin
            state <= CONV_IDLE;
            per   <= '0;
        end else if (busy && tick) begin
            per   <= per + 1'b1;
        end
    end

    // Capture the clock select when a conversion is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)         sel_cap <= '0;
        else if (start_acc) sel_cap <= clk_sel;
    end

endmodule

// File: rtl/sar_approx_reg.sv
// Module: successive-approximation register holding trial code and result.
// Assumes decide pulses once per resolved bit, top bit first.
module sar_approx_reg #(
    parameter int RES_BITS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_acc,
    input  logic                decide,
    input  logic                done,
    input  logic                cmp_in,
    output logic [RES_BITS-1:0] code,
    output logic [RES_BITS-1:0] result
);

    localparam logic [RES_BITS-1:0] TOP_BIT = RES_BITS'(1) << (RES_BITS - 1);

    logic [RES_BITS-1:0] mask;
    logic [RES_BITS-1:0] kept;
    logic [RES_BITS-1:0] next_code;

    // Per-bit keep-or-drop decision for the bit under trial.
    for (genvar i = 0; i < RES_BITS; i++) begin : g_bit
        always_comb kept[i] = mask[i] ? cmp_in : code[i];
    end

    // Next trial: resolved bits plus the next lower trial bit.
    always_comb next_code = kept | (mask >> 1);

    // Trial code and mask update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= '0;
            mask <= '0;
        end else if (start_acc) begin
            code <= TOP_BIT;
            mask <= TOP_BIT;
        end else if (done) begin
            code <= '0;
            mask <= '0;
        end else if (decide) begin
            code <= next_code;
            mask <= mask >> 1;
        end
    end

    // Result register, loaded only on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)    result <= '0;
        else if (done) result <= kept;
    end

endmodule

// File: rtl/sar_flag_irq.sv
// Module: sticky completion flag and interrupt request.
// Assumes done is a one-cycle pulse; completion wins over a clear.
module sar_flag_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic done,
    input  logic flag_clr,
    input  logic irq_en,
    output logic done_flag,
    output logic irq
);

    // Flag set by hardware, cleared only by software.
    always_ff @(posedge clk) begin
        if (!rst_n)        done_flag <= 1'b0;
        else if (done)     done_flag <= 1'b1;
        else if (flag_clr) done_flag <= 1'b0;
    end

    // Request is unclocked so it reaches a sleeping core.
    always_comb irq = done_flag && irq_en;

endmodule

// File: rtl/sar_conv_ctrl.sv
// Module: top of the SAR conversion sequencer.
// Assumes cmp_in reflects the comparison against dac_code in the same cycle
// and rc_tick is already synchronous to clk.
module sar_conv_ctrl
    import sar_conv_pkg::*;
#(
    parameter int RES_BITS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                core_sleep,
    input  logic                rc_tick,
    input  logic [2:0]          clk_sel,
    input  logic                start_wr,
    input  logic                flag_clr,
    input  logic                irq_en,
    input  logic                cmp_in,
    output logic                busy,
    output logic [RES_BITS-1:0] dac_code,
    output logic [RES_BITS-1:0] result,
    output logic                done_flag,
    output logic                irq
);

    localparam int PERIODS = RES_BITS + 1;

    logic             start_acc;
    logic             decide;
    logic             done;
    logic             tick;
    logic [SEL_W-1:0] sel_cap;

    sar_seq #(.PERIODS(PERIODS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_wr  (start_wr),
        .clk_sel   (clk_sel),
        .tick      (tick),
        .busy      (busy),
        .start_acc (start_acc),
        .decide    (decide),
        .done      (done),
        .sel_cap   (sel_cap)
    );

    sar_tick_gen #(.CNT_W(MAX_EXP)) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (busy),
        .restart    (start_acc),
        .sel_cap    (sel_cap),
        .core_sleep (core_sleep),
        .rc_tick    (rc_tick),
        .tick       (tick)
    );

    sar_approx_reg #(.RES_BITS(RES_BITS)) u_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_acc (start_acc),
        .decide    (decide),
        .done      (done),
        .cmp_in    (cmp_in),
        .code      (dac_code),
        .result    (result)
    );

    sar_flag_irq u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .done      (done),
        .flag_clr  (flag_clr),
        .irq_en    (irq_en),
        .done_flag (done_flag),
        .irq       (irq)
    );

endmodule

// File: rtl/sar_conv_ctrl_chk.sv
// Module: assertion checker bound to sar_conv_ctrl.
// Assumes it sees the top's ports and the captured clock select.
module sar_conv_ctrl_chk #(
    parameter int RES_BITS = 10
) (
    input logic                clk,
    input logic                rst_n,
    input logic                core_sleep,
    input logic                flag_clr,
    input logic                busy,
    input logic [RES_BITS-1:0] dac_code,
    input logic [RES_BITS-1:0] result,
    input logic                done_flag,
    input logic [2:0]          sel_cap
);

    localparam logic [RES_BITS-1:0] TOP_BIT = RES_BITS'(1) << (RES_BITS - 1);

    a_r5_busy_ends_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done_flag);

    a_r4_result_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(busy) |-> $stable(result));

    a_r12_dac_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (dac_code == '0));

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && !flag_clr) |=> done_flag);

    a_r8_flag_rises_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $fell(busy));

    a_r3_first_trial_top: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (dac_code == TOP_BIT));

    a_r10_sleep_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && core_sleep && !(sel_cap[1] && sel_cap[0])) |=> (busy && $stable(dac_code)));

endmodule

bind sar_conv_ctrl sar_conv_ctrl_chk #(.RES_BITS(RES_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .core_sleep (core_sleep),
    .flag_clr   (flag_clr),
    .busy       (busy),
    .dac_code   (dac_code),
    .result     (result),
    .done_flag  (done_flag),
    .sel_cap    (sel_cap)
);

// File: tb/tb_sar_conv_ctrl.sv
module tb_sar_conv_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       core_sleep = 1'b0;
    logic       rc_tick = 1'b0;
    logic [2:0] clk_sel = 3'b000;
    logic       start_wr = 1'b0;
    logic       flag_clr = 1'b0;
    logic       irq_en = 1'b0;
    logic       cmp_in;
    logic       busy;
    logic [9:0] dac_code;
    logic [9:0] result;
    logic       done_flag;
    logic       irq;
    logic [9:0] vin = 10'd0;
    logic       rc_on = 1'b0;

    int errors = 0;
    int checks = 0;
    bit cmp_on = 1'b0;
    bit ended  = 1'b0;

    always #4 clk = ~clk;

    // Comparator and input voltage model.
    assign cmp_in = (vin >= dac_code);

    sar_conv_ctrl dut (
        .clk(clk), .rst_n(rst_n), .core_sleep(core_sleep), .rc_tick(rc_tick),
        .clk_sel(clk_sel), .start_wr(start_wr), .flag_clr(flag_clr),
        .irq_en(irq_en), .cmp_in(cmp_in), .busy(busy), .dac_code(dac_code),
        .result(result), .done_flag(done_flag), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // RC strobe: one pulse every fifth cycle when enabled.
    int rc_cnt = 0;
    always @(negedge clk) begin
        if (rc_on) begin
            rc_cnt  = (rc_cnt + 1) % 5;
            rc_tick <= (rc_cnt == 0);
        end else begin
            rc_tick <= 1'b0;
        end
    end

    // Behavioural reference model, advanced at every rising edge.
    int m_busy = 0, m_per = 0, m_cnt = 0, m_div = 2, m_rc = 0;
    int m_code = 0, m_result = 0, m_flag = 0;
    always @(posedge clk) begin
        int done_now;
        bit tk;
        done_now = 0;
        if (!rst_n) begin
            m_busy = 0; m_per = 0; m_cnt = 0; m_code = 0; m_result = 0; m_flag = 0;
        end else begin
            if (m_busy != 0) begin
                tk = 1'b0;
                if (m_rc != 0) tk = rc_tick;
                else if (!core_sleep) begin
                    if (m_cnt == m_div - 1) begin tk = 1'b1; m_cnt = 0; end
                    else m_cnt++;
                end
                if (tk) begin
                    if (m_per > 0) begin
                        int bp;
                        bp = 10 - m_per;
                        if (!(int'(vin) >= m_code)) m_code -= (1 << bp);
                        if (bp > 0) m_code += (1 << (bp - 1));
                    end
                    if (m_per == 10) begin
                        m_result = m_code; m_code = 0; m_busy = 0; done_now = 1;
                    end else m_per++;
                end
            end else if (start_wr) begin
                m_busy = 1; m_per = 0; m_cnt = 0; m_code = 512;
                m_rc = (clk_sel[1:0] == 2'b11) ? 1 : 0;
                case (clk_sel)
                    3'b000: m_div = 2;
                    3'b100: m_div = 4;
                    3'b001: m_div = 8;
                    3'b101: m_div = 16;
                    3'b010: m_div = 32;
                    default: m_div = 64;
                endcase
            end
            if (done_now != 0) m_flag = 1;
            else if (flag_clr) m_flag = 0;
        end
    end

    // Compare every cycle, shortly after the edge.
    always @(posedge clk) begin
        #2;
        if (cmp_on) begin
            check("R5 busy", int'(busy), m_busy);
            check("R3 dac_code", int'(dac_code), m_code);
            check("R4 result", int'(result), m_result);
            check("R8 done_flag", int'(done_flag), m_flag);
            check("R9 irq", int'(irq), (m_flag != 0 && irq_en) ? 1 : 0);
        end
    end

    // Run one conversion; returns the number of cycles busy stayed high.
    // poke: start pulse and select change mid-run. gap: sleep cycles.
    // clr_end: pulse flag_clr in the completion cycle.
    task automatic run_conv(input logic [2:0] sel, input logic [9:0] v,
                            input bit poke, input int gap, input bit clr_end,
                            input int exp_n, output int n);
        @(negedge clk);
        clk_sel  = sel;
        vin      = v;
        start_wr = 1'b1;
        @(negedge clk);
        start_wr = 1'b0;
        n = 0;
        while (busy && n < 20000) begin
            n++;
            start_wr = (poke && n == 5);
            if (poke && n == 5) clk_sel = 3'b110;
            if (gap > 0) core_sleep = (n >= 10 && n < 10 + gap);
            flag_clr = (clr_end && n == exp_n);
            @(negedge clk);
        end
        start_wr   = 1'b0;
        flag_clr   = 1'b0;
        if (gap > 0) core_sleep = 1'b0;
    endtask

    initial begin
        int n;
        logic [2:0] sels [6] = '{3'b000, 3'b100, 3'b001, 3'b101, 3'b010, 3'b110};
        int divs [6] = '{2, 4, 8, 16, 32, 64};
        logic [9:0] vals [6] = '{10'h2A5, 10'h3FF, 10'h000, 10'h155, 10'h200, 10'h1FF};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_on = 1'b1;
        // R11 reset state
        check("R11 busy", int'(busy), 0);
        check("R11 flag", int'(done_flag), 0);
        check("R11 irq", int'(irq), 0);
        check("R11 result", int'(result), 0);
        check("R11 dac_code", int'(dac_code), 0);

        // R1 all six divisors, R3/R4 codes, R8 flag with irq disabled, R12 idle
        for (int i = 0; i < 6; i++) begin
            run_conv(sels[i], vals[i], 1'b0, 0, 1'b0, 0, n);
            check("R1 length", n, 11 * divs[i]);
            check("R4 result", int'(result), int'(vals[i]));
            check("R8 flag set with irq_en low", int'(done_flag), 1);
            check("R9 irq low when disabled", int'(irq), 0);
            check("R12 dac idle", int'(dac_code), 0);
            flag_clr = 1'b1;
            @(negedge clk);
            flag_clr = 1'b0;
            check("R8 flag cleared", int'(done_flag), 0);
        end

        // R9 interrupt with enable
        run_conv(3'b000, 10'h0F0, 1'b0, 0, 1'b0, 0, n);
        check("R8 flag held", int'(done_flag), 1);
        irq_en = 1'b1;
        #1;
        check("R9 irq raised", int'(irq), 1);
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check("R9 irq drops with flag", int'(irq), 0);

        // R6 and R7: start pulse and select change mid-run
        run_conv(3'b100, 10'h333, 1'b1, 0, 1'b0, 0, n);
        check("R6 R7 length unchanged", n, 44);
        check("R6 result unchanged", int'(result), 'h333);
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;

        // R10 sleep freezes a divided-clock conversion
        run_conv(3'b001, 10'h2C8, 1'b0, 40, 1'b0, 0, n);
        check("R10 sleep adds cycles", n, 88 + 40);
        check("R10 result", int'(result), 'h2C8);
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;

        // R8 completion and clear in the same cycle
        run_conv(3'b000, 10'h111, 1'b0, 0, 1'b1, 22, n);
        check("R8 completion beats clear", int'(done_flag), 1);
        check("R8 collision length", n, 22);
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;

        // R2 and R10: RC-timed conversion while asleep, irq during sleep (R9)
        rc_on = 1'b1;
        core_sleep = 1'b1;
        run_conv(3'b011, 10'h3A7, 1'b0, 0, 1'b0, 0, n);
        check("R2 RC length lower", (n >= 51) ? 1 : 0, 1);
        check("R2 RC length upper", (n <= 55) ? 1 : 0, 1);
        check("R2 RC result", int'(result), 'h3A7);
        check("R9 irq while asleep", int'(irq), 1);
        core_sleep = 1'b0;
        flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        run_conv(3'b111, 10'h05A, 1'b0, 0, 1'b0, 0, n);
        check("R2 RC 111 result", int'(result), 'h05A);
        rc_on = 1'b0;

        repeat (4) @(negedge clk);
        if (!ended) begin
            ended = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule